// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block is a synthesizable, reduced-size model of a synchronous burst SRAM whose read path has no output register and whose bus needs no idle cycle when a read follows a write or a write follows a read. Each word is 18 bits wide and is split into two 9-bit lanes that can be written on their own. On every rising clock edge at which the clock enable is high, the block does one of two things. It either captures a fresh access (address, read or write direction, chip selects) or it steps a two-bit beat counter that walks through the four words of an aligned group.

A read returns its word on the output bus in the cycle right after the edge that registered the access, straight from the array. A write takes its data on the next enabled edge, so data for one beat and the control for the following beat share the same edge. The bus is modelled as separate input data, output data and output-enable signals. A sleep request parks the device two edges after it is raised and releases it two edges after it drops. The array depth is set by the address-width parameter.

Top module: `ft_burst_sram`

## Requirements
- R1: After reset `d_oe` is 0 and `d_out` is all zeros.
- R2: An enabled edge with `seq_step` = 0 captures `addr`, the write direction (`wr_n` = 0 means write) and the chip selects. For a selected read, the word at `addr` is on `d_out` with `d_oe` = 1 during the cycle after that edge, provided `rd_gate_n` is 0.
- R3: An enabled edge with `seq_step` = 1 advances the beat count by one, modulo 4. With `burst_lin` = 1 captured at load, the word used is upper address bits unchanged and low two bits = (loaded low bits + count) mod 4. The sequence wraps after four beats.
- R4: With `burst_lin` = 0 captured at load, the low two bits are (loaded low bits) XOR count. The upper bits never change during a burst.
- R5: For a write beat, `d_in` sampled at the next enabled edge is stored at that beat's address. `lane_wr_n[0]` = 0 enables bits 8:0 and `lane_wr_n[1]` = 0 enables bits 17:9. The lane enables are sampled at the same edge as the beat's access.
- R6: A read may be loaded at the edge that takes the last write data. It returns the just-written word in the next cycle, with no idle cycle.
- R7: While `clk_en` is 0, no access state changes and no write takes place. Read data stays on the bus, and a pending write waits for the next enabled edge.
- R8: Chip selects count only at load edges. The block is selected when `sel_n` = 0 and `sel` = 1. A deselected load keeps `d_oe` at 0 for the whole following burst, and its writes are dropped.
- R9: `rd_gate_n` = 1 forces `d_oe` to 0. `d_oe` is also 0 during write beats. Whenever `d_oe` is 0, `d_out` is all zeros.
- R10: When `sleep_req` is sampled 1 at edge e, the block is asleep from edge e+1 onwards. While asleep, `d_oe` is 0, writes are dropped, loads are ignored and any burst in progress is cancelled. The sleep stages run whatever `clk_en` is.
- R11: When `sleep_req` is sampled 0 at edge w, the block is awake after edge w+1. The bus stays off until a new selected read is loaded, which then works as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | High: the edge is acted upon |
| seq_step | input | 1 | 0: load a new access, 1: advance the beat count |
| sel_n | input | 1 | Active-low chip select, sampled at load |
| sel | input | 1 | Active-high chip select, sampled at load |
| wr_n | input | 1 | 0: write access, 1: read access, sampled at load |
| lane_wr_n | input | 2 | Active-low per-lane write enables |
| addr | input | ADDR_W | Word address, sampled at load |
| burst_lin | input | 1 | Beat order, 1 linear, 0 interleaved, sampled at load |
| rd_gate_n | input | 1 | Active-low output gate |
| sleep_req | input | 1 | Sleep request |
| d_in | input | 18 | Write data |
| d_out | output | 18 | Read data, zero when not driven |
| d_oe | output | 1 | Bus drive enable |

## Verification
On one enabled edge, the block can commit the data of the previous write beat and also register a new access, either a fresh load or the next beat. When that new access is a read of the same word, its data must already show the update in the following cycle. The bench provokes this by ending write bursts with a read load at the same edge that carries the last write data. It then judges each cycle's bus against a behavioural model that applies the write before it updates the access. Sleep entry during a running read burst gives a second overlap, and the one-edge gap before the bus turns off is checked.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_INC = 1'b1
  } burst_ord_e;

  // low two address bits of the current beat
  function automatic logic [1:0] beat_offset(input burst_ord_e ord,
                                             input logic [1:0] seed,
                                             input logic [1:0] cnt);
    logic [1:0] res;
    if (ord == ORD_INC) res = seed + cnt;
    else                res = seed ^ cnt;
    return res;
  endfunction

endpackage

// File: rtl/ftb_rst_sync.sv
module ftb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];

endmodule

// File: rtl/ftb_nap_ctl.sv
module ftb_nap_ctl #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic asleep
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], sleep_req};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign asleep = sh_q[STAGES-1];

endmodule

// File: rtl/ftb_burst_seq.sv
module ftb_burst_seq
  import ftb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic              load,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              lin_in,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q, hi_d;
  logic [1:0]      seed_q, seed_d;
  logic [1:0]      cnt_q, cnt_d;
  burst_ord_e      ord_q, ord_d;

  always_comb begin
    hi_d   = hi_q;
    seed_d = seed_q;
    cnt_d  = cnt_q;
    ord_d  = ord_q;
    if (adv_en) begin
      if (load) begin
        hi_d   = ext_addr[ADDR_W-1:2];
        seed_d = ext_addr[1:0];
        cnt_d  = 2'd0;
        ord_d  = burst_ord_e'(lin_in);
      end else begin
        cnt_d  = cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      seed_q <= 2'd0;
      cnt_q  <= 2'd0;
      ord_q  <= ORD_INC;
    end else begin
      hi_q   <= hi_d;
      seed_q <= seed_d;
      cnt_q  <= cnt_d;
      ord_q  <= ord_d;
    end
  end

  assign cur_addr = {hi_q, beat_offset(ord_q, seed_q, cnt_q)};

endmodule

// File: rtl/ftb_lane_mem.sv
module ftb_lane_mem #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        lane_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && lane_en[g]) cell_q[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cell_q[addr];
  end

endmodule

// File: rtl/ft_burst_sram.sv
module ft_burst_sram #(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 2,
  parameter int LANE_W     = 9,
  parameter int NAP_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    seq_step,
  input  logic                    sel_n,
  input  logic                    sel,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burst_lin,
  input  logic                    rd_gate_n,
  input  logic                    sleep_req,
  input  logic [LANES*LANE_W-1:0] d_in,
  output logic [LANES*LANE_W-1:0] d_out,
  output logic                    d_oe
);

  localparam int DATA_W = LANES * LANE_W;

  logic              rst_sync_n;
  logic              asleep;
  logic              adv_en;
  logic              sel_ok;
  logic              mem_we;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] rd_word;

  logic             vld_q, vld_d;
  logic             wr_q, wr_d;
  logic [LANES-1:0] lane_q, lane_d;

  ftb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ftb_nap_ctl #(.STAGES(NAP_STAGES)) u_nap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sleep_req (sleep_req),
    .asleep    (asleep)
  );

  assign adv_en = clk_en & ~asleep;
  assign sel_ok = ~sel_n & sel;

  always_comb begin
    vld_d  = vld_q;
    wr_d   = wr_q;
    lane_d = lane_q;
    if (asleep) begin
      vld_d = 1'b0;
    end else if (clk_en) begin
      lane_d = ~lane_wr_n;
      if (!seq_step) begin
        vld_d = sel_ok;
        wr_d  = ~wr_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      wr_q   <= 1'b0;
      lane_q <= '0;
    end else begin
      vld_q  <= vld_d;
      wr_q   <= wr_d;
      lane_q <= lane_d;
    end
  end

  ftb_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv_en   (adv_en),
    .load     (~seq_step),
    .ext_addr (addr),
    .lin_in   (burst_lin),
    .cur_addr (cur_addr)
  );

  // data of the registered write beat is taken on the next enabled edge
  assign mem_we = adv_en & vld_q & wr_q;

  ftb_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .wr_en   (mem_we),
    .lane_en (lane_q),
    .addr    (cur_addr),
    .wdata   (d_in),
    .rdata   (rd_word)
  );

  assign d_oe  = vld_q & ~wr_q & ~rd_gate_n & ~asleep;
  assign d_out = d_oe ? rd_word : '0;

endmodule

// File: rtl/ftb_sram_chk.sv
module ftb_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              clk_en,
  input logic              seq_step,
  input logic              sel_n,
  input logic              sel,
  input logic              sleep_req,
  input logic              rd_gate_n,
  input logic              d_oe,
  input logic [DATA_W-1:0] d_out,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              asleep
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)        age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_gate_n |-> !d_oe); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !d_oe |-> (d_out == '0)); // R9

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clk_en |=> $stable(acc_addr)); // R7

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en && seq_step) |=> (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2]))); // R4

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en && !seq_step && !(!sel_n && sel) && !asleep) |=> !d_oe); // R8

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q >= 2'd2 && $past(sleep_req, 2)) |-> (!d_oe && asleep)); // R10

endmodule

bind ft_burst_sram ftb_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .clk_en     (clk_en),
  .seq_step   (seq_step),
  .sel_n      (sel_n),
  .sel        (sel),
  .sleep_req  (sleep_req),
  .rd_gate_n  (rd_gate_n),
  .d_oe       (d_oe),
  .d_out      (d_out),
  .acc_addr   (cur_addr),
  .asleep     (asleep)
);

// File: tb/ft_burst_sram_tb_top.sv
module ft_burst_sram_tb_top;

  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en, seq_step, sel_n, sel, wr_n, burst_lin, rd_gate_n, sleep_req;
  logic [1:0]    lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] d_in;
  logic [DW-1:0] d_out;
  logic          d_oe;

  int    n_chk = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // behavioural reference state
  bit             m_vld, m_wr, m_lin, sp1, asl;
  bit [1:0]       m_lanes;
  int             m_base, m_cnt;
  logic [DW-1:0]  mm [int];
  bit [1:0]       mk [int];

  always #10 clk = ~clk;

  ft_burst_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .seq_step(seq_step),
    .sel_n(sel_n), .sel(sel), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .burst_lin(burst_lin), .rd_gate_n(rd_gate_n),
    .sleep_req(sleep_req), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(32'h2A5A5 ^ (i * 32'h0137) ^ (i << 11));
  endfunction

  function automatic int m_cur();
    int low;
    low = m_lin ? ((m_base + m_cnt) & 3) : ((m_base ^ m_cnt) & 3);
    return (m_base & ~3) | low;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vld = 0; m_wr = 0; m_lin = 1; sp1 = 0; asl = 0;
      m_lanes = 0; m_base = 0; m_cnt = 0;
    end else begin
      if (!asl && clk_en && m_vld && m_wr) begin
        int a;
        logic [DW-1:0] w;
        a = m_cur();
        w = mm.exists(a) ? mm[a] : '0;
        if (!mk.exists(a)) mk[a] = 2'b00;
        if (m_lanes[0]) begin w[8:0]  = d_in[8:0];  mk[a][0] = 1'b1; end
        if (m_lanes[1]) begin w[17:9] = d_in[17:9]; mk[a][1] = 1'b1; end
        mm[a] = w;
      end
      if (asl) m_vld = 0;
      else if (clk_en) begin
        m_lanes = ~lane_wr_n;
        if (!seq_step) begin
          m_vld = !sel_n && sel; m_wr = !wr_n;
          m_base = int'(addr); m_cnt = 0; m_lin = burst_lin;
        end else m_cnt = (m_cnt + 1) & 3;
      end
      asl = sp1;
      sp1 = sleep_req;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      bit eo;
      int a;
      eo = m_vld && !m_wr && !rd_gate_n && !asl;
      a = m_cur();
      chk({phase, " model oe"}, 32'(d_oe), 32'(eo));
      if (!eo) chk({phase, " model idle out"}, 32'(d_out), 32'd0);
      else if (mk.exists(a) && mk[a] == 2'b11) chk({phase, " model data"}, 32'(d_out), 32'(mm[a]));
    end
  end

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic ld(input bit w, input int a, input bit lin, input logic [DW-1:0] din,
                    input logic [1:0] ln);
    clk_en = 1; seq_step = 0; wr_n = !w; addr = AW'(a); burst_lin = lin;
    d_in = din; lane_wr_n = ln; sel_n = 0; sel = 1;
    tick();
  endtask

  task automatic adv(input logic [DW-1:0] din);
    clk_en = 1; seq_step = 1; d_in = din; lane_wr_n = 2'b00; sel_n = 1; sel = 0;
    tick();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    clk_en = 0; seq_step = 1; sel_n = 1; sel = 0; wr_n = 1; lane_wr_n = 2'b00;
    addr = '0; burst_lin = 1; rd_gate_n = 0; sleep_req = 0; d_in = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    repeat (3) tick();

    phase = "R1";
    chk("R1 oe after reset", 32'(d_oe), 32'd0);
    chk("R1 out after reset", 32'(d_out), 32'd0);
    cmp_on = 1'b1;

    // linear write burst, read loaded on the last data edge
    phase = "R3";
    ld(1, 'h10, 1, '0, 2'b00);
    adv(pat(0)); adv(pat(1)); adv(pat(2));
    phase = "R6";
    ld(0, 'h10, 1, pat(3), 2'b00);
    chk("R2 first read beat", 32'(d_out), 32'(pat(0)));
    phase = "R3";
    adv('0); chk("R3 linear beat 1", 32'(d_out), 32'(pat(1)));
    adv('0); chk("R3 linear beat 2", 32'(d_out), 32'(pat(2)));
    adv('0); chk("R6 last written beat", 32'(d_out), 32'(pat(3)));
    adv('0); chk("R3 linear wrap", 32'(d_out), 32'(pat(0)));

    // interleaved order: seed 2 writes 22,23,20,21; seed 1 reads 21,20,23,22
    phase = "R4";
    ld(1, 'h22, 0, '0, 2'b00);
    adv(pat(10)); adv(pat(11)); adv(pat(12));
    ld(0, 'h21, 0, pat(13), 2'b00);
    chk("R4 xor beat 0", 32'(d_out), 32'(pat(13)));
    adv('0); chk("R4 xor beat 1", 32'(d_out), 32'(pat(12)));
    adv('0); chk("R4 xor beat 2", 32'(d_out), 32'(pat(11)));
    adv('0); chk("R4 xor beat 3", 32'(d_out), 32'(pat(10)));

    // lane gating: second write enables only bits 8:0
    phase = "R5";
    ld(1, 'h05, 1, '0, 2'b00);
    ld(1, 'h05, 1, pat(20), 2'b10);
    ld(0, 'h05, 1, 18'h3FFFF, 2'b00);
    chk("R5 lower lane only", 32'(d_out), 32'({pat(20)[17:9], 9'h1FF}));

    // clock enable low holds read data and defers a pending write
    phase = "R7";
    ld(0, 'h10, 1, '0, 2'b00);
    clk_en = 0; seq_step = 1; addr = AW'('h3F); d_in = 18'h15555;
    tick(); tick();
    chk("R7 read held", 32'(d_out), 32'(pat(0)));
    adv('0); chk("R7 step after hold", 32'(d_out), 32'(pat(1)));
    ld(1, 'h30, 1, '0, 2'b00);
    clk_en = 0; seq_step = 0; wr_n = 1; d_in = 18'h0AAAA;
    tick(); tick();
    ld(0, 'h30, 1, pat(30), 2'b00);
    chk("R7 deferred write", 32'(d_out), 32'(pat(30)));

    // deselected write burst leaves memory alone
    phase = "R8";
    clk_en = 1; seq_step = 0; wr_n = 0; addr = AW'('h10); sel_n = 0; sel = 0;
    lane_wr_n = 2'b00; d_in = '0;
    tick();
    adv(18'h00000);
    chk("R8 desel oe", 32'(d_oe), 32'd0);
    adv(18'h00000);
    ld(0, 'h10, 1, '0, 2'b00);
    chk("R8 data kept", 32'(d_out), 32'(pat(0)));

    // output gate and write beats
    phase = "R9";
    ld(0, 'h11, 1, '0, 2'b00);
    rd_gate_n = 1; #1;
    chk("R9 gate oe", 32'(d_oe), 32'd0);
    chk("R9 gate out", 32'(d_out), 32'd0);
    rd_gate_n = 0; #1;
    chk("R9 gate open", 32'(d_out), 32'(pat(1)));
    ld(1, 'h11, 1, '0, 2'b00);
    chk("R9 write beat oe", 32'(d_oe), 32'd0);
    ld(0, 'h12, 1, pat(1), 2'b00);

    // sleep entry, ignored write while asleep, wake
    phase = "R10";
    sleep_req = 1;
    adv('0);
    chk("R10 one edge still on", 32'(d_oe), 32'd1);
    chk("R10 one edge data", 32'(d_out), 32'(pat(3)));
    adv('0);
    chk("R10 asleep oe", 32'(d_oe), 32'd0);
    ld(1, 'h12, 1, '0, 2'b00);
    adv(18'h3FFFF); adv(18'h3FFFF);
    phase = "R11";
    sleep_req = 0;
    adv('0);
    chk("R11 still parked", 32'(d_oe), 32'd0);
    adv('0);
    chk("R11 awake bus off", 32'(d_oe), 32'd0);
    ld(0, 'h12, 1, '0, 2'b00);
    chk("R11 read after wake", 32'(d_out), 32'(pat(2)));
    clk_en = 0;
    tick(); tick();
    finish_run();
  end

endmodule